// File: doc/BRIEF.md
# Asynchronous ROM Read Sequencer

This block sits between a synchronous host and a 16-bit parallel read-only memory that has an 18-bit address and no clock of its own. The host offers one address at a time on a valid/ready handshake. The sequencer then drives that address and pulls the device-select strobe low. It lowers the shared read strobe only as late as the access allows, and captures the word once every memory delay has run out. The word goes back to the host on a one-cycle response strobe.

All memory delays are given in nanoseconds, together with the clock period. The block rounds each one up to whole cycles.

- The read strobe falls `max(addr, select) - read_enable` cycles after the address is driven.
- Capture happens one cycle after the latest of the three data-valid points.
- After both strobes are released, the sequencer waits out the float delay before it accepts the next request, so two devices never drive the data lines at the same time.

With the defaults (10 ns clock, delays of 90/90/50/30 ns), the timing is as follows:

- The read strobe falls 4 cycles after the address is driven.
- Capture is at cycle 10.
- The host sees ready again 3 cycles after release.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is high, and on the first sample after reset is applied mid-access, `mem_sel_n` and `mem_rden_n` are 1, `mem_addr` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. After that edge, `mem_addr` equals the request address, `mem_sel_n` is 0 and `req_ready` is 0.
- R3: `mem_rden_n` falls exactly OE_LEAD cycles after the edge that drives the address (4 with defaults, 0 means the same edge). It is never 0 while `mem_sel_n` is 1.
- R4: The word is captured on the edge SAMP_AT+1 cycles after the address edge (10 with defaults). The captured word is what the memory presents once all three delays have elapsed.
- R5: `rsp_valid` is a single-cycle pulse carrying the captured word in `rsp_data`. On the same edge, `mem_sel_n` and `mem_rden_n` both return to 1.
- R6: `mem_addr` does not change while `mem_sel_n` is 0.
- R7: `req_ready` returns exactly FLOAT_CYC cycles after the release edge (3 with defaults). `mem_sel_n` never falls earlier than FLOAT_CYC+1 cycles after a release.
- R8: `req_valid` and `req_addr` are ignored while `req_ready` is 0. They change neither the address nor the timing of the access in progress.
- R9: In idle with `req_valid` at 0, no access starts: `mem_sel_n` stays 1 and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_addr | input | ADDR_W (18) | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe, read word available |
| rsp_data | output | DATA_W (16) | Captured read word |
| mem_addr | output | ADDR_W (18) | Address lines to the memory |
| mem_sel_n | output | 1 | Device select, active low |
| mem_rden_n | output | 1 | Read enable to memory outputs, active low |
| mem_data_in | input | DATA_W (16) | Data lines from the memory |

## Verification
The hardest situation to reach from the ports is a capture edge placed too early, because a word captured early can look plausible. The bench's memory model returns the complement of the correct word until each delay, measured in nanoseconds from its own strobe or address change, has elapsed. An early capture therefore shows up as a data mismatch. Requests offered during a busy access, and a reset pulled in the middle of an access, are injected on purpose. They show that the address holds and that the strobes return to their idle levels.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RDEN_WAIT,
        ST_SAMPLE,
        ST_FLOAT
    } rd_state_e;

    typedef struct packed {
        logic launch;
        logic rden_on;
        logic capture;
    } seq_ctl_t;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
        return (ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int unsigned OE_LEAD   = 4,
    parameter int unsigned SAMP_AT   = 9,
    parameter int unsigned FLOAT_CYC = 3,
    parameter int unsigned CNT_W     = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    output logic     idle,
    output seq_ctl_t ctl
);
    rd_state_e  state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt + 1'b1;
    assign idle    = (state == ST_IDLE);

    generate
        if (OE_LEAD == 0) begin : g_rden_at_launch
            assign ctl.rden_on = (state == ST_IDLE) && req_valid;
        end else begin : g_rden_late
            assign ctl.rden_on = (state == ST_ADDR) && (cnt_inc == CNT_W'(OE_LEAD));
        end
    endgenerate

    assign ctl.launch  = (state == ST_IDLE) && req_valid;
    assign ctl.capture = (state == ST_SAMPLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req_valid) begin
                        state <= (OE_LEAD == 0) ? ST_RDEN_WAIT : ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    cnt <= cnt_inc;
                    if (cnt_inc == CNT_W'(OE_LEAD)) begin
                        state <= ST_RDEN_WAIT;
                    end
                end
                ST_RDEN_WAIT: begin
                    cnt <= cnt_inc;
                    if (cnt_inc >= CNT_W'(SAMP_AT)) begin
                        state <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    cnt   <= '0;
                    state <= (FLOAT_CYC == 0) ? ST_IDLE : ST_FLOAT;
                end
                ST_FLOAT: begin
                    cnt <= cnt_inc;
                    if (cnt_inc >= CNT_W'(FLOAT_CYC)) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/eprom_rd_bus.sv
module eprom_rd_bus
    import eprom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_rden_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_sel_n  <= 1'b1;
            mem_rden_n <= 1'b1;
        end else begin
            if (ctl.launch) begin
                mem_addr  <= req_addr;
                mem_sel_n <= 1'b0;
            end
            if (ctl.rden_on) begin
                mem_rden_n <= 1'b0;
            end
            if (ctl.capture) begin
                mem_sel_n  <= 1'b1;
                mem_rden_n <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture
    import eprom_rd_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    input  logic [DATA_W-1:0] mem_data_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= ctl.capture;
            if (ctl.capture) begin
                rsp_data <= mem_data_in;
            end
        end
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_NS        = 10,
    parameter int unsigned ADDR_DATA_NS  = 90,
    parameter int unsigned SEL_DATA_NS   = 90,
    parameter int unsigned RDEN_DATA_NS  = 50,
    parameter int unsigned FLOAT_NS      = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_rden_n,
    input  logic [DATA_W-1:0] mem_data_in
);
    localparam int unsigned ADDR_CYC  = ns_to_cyc(ADDR_DATA_NS, CLK_NS);
    localparam int unsigned SEL_CYC   = ns_to_cyc(SEL_DATA_NS, CLK_NS);
    localparam int unsigned RDEN_CYC  = ns_to_cyc(RDEN_DATA_NS, CLK_NS);
    localparam int unsigned FLOAT_CYC = ns_to_cyc(FLOAT_NS, CLK_NS);
    localparam int unsigned VALID_CYC = max_u(ADDR_CYC, SEL_CYC);
    localparam int unsigned OE_LEAD   = (VALID_CYC > RDEN_CYC) ? VALID_CYC - RDEN_CYC : 0;
    localparam int unsigned SAMP_AT   = max_u(max_u(VALID_CYC, OE_LEAD + RDEN_CYC), 1);
    localparam int unsigned CNT_W     = $clog2(max_u(SAMP_AT, FLOAT_CYC) + 2);

    seq_ctl_t ctl;
    logic     idle;

    eprom_rd_seq #(
        .OE_LEAD  (OE_LEAD),
        .SAMP_AT  (SAMP_AT),
        .FLOAT_CYC(FLOAT_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .idle     (idle),
        .ctl      (ctl)
    );

    eprom_rd_bus #(
        .ADDR_W(ADDR_W)
    ) u_bus (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .req_addr  (req_addr),
        .mem_addr  (mem_addr),
        .mem_sel_n (mem_sel_n),
        .mem_rden_n(mem_rden_n)
    );

    eprom_rd_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .mem_data_in(mem_data_in),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    assign req_ready = idle;
endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk #(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned FLOAT_CYC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_rden_n
);
    logic [7:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= 8'hFF;
        end else if (rsp_valid) begin
            gap <= 8'd1;
        end else if (gap != 8'hFF) begin
            gap <= gap + 8'd1;
        end
    end

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_sel_n && mem_rden_n));  // R2

    AST_RDEN_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        !mem_rden_n |-> !mem_sel_n);  // R3

    AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (mem_sel_n && mem_rden_n && !$past(mem_rden_n)));  // R5

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);  // R5

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr));  // R6

    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_sel_n) |-> (int'(gap) >= int'(FLOAT_CYC) + 1));  // R7
endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .FLOAT_CYC(FLOAT_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_rden_n(mem_rden_n)
);

// File: tb/sim_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_eprom_rd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int T_ADDR = 90;
    localparam int T_SEL  = 90;
    localparam int T_RDEN = 50;
    localparam int T_FLT  = 30;

    localparam int C_ADDR  = (T_ADDR + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_SEL   = (T_SEL + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_RDEN  = (T_RDEN + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_FLT   = (T_FLT + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_VALID = (C_ADDR > C_SEL) ? C_ADDR : C_SEL;
    localparam int EXP_LEAD = (C_VALID > C_RDEN) ? C_VALID - C_RDEN : 0;
    localparam int EXP_SAMP = ((C_VALID > EXP_LEAD + C_RDEN) ? C_VALID : EXP_LEAD + C_RDEN) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_addr;
    logic mem_sel_n;
    logic mem_rden_n;
    logic [DW-1:0] mem_data_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eprom_rd_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD),
        .ADDR_DATA_NS(T_ADDR), .SEL_DATA_NS(T_SEL),
        .RDEN_DATA_NS(T_RDEN), .FLOAT_NS(T_FLT)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_rden_n(mem_rden_n),
        .mem_data_in(mem_data_in)
    );

    function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
        return a[15:0] ^ {a[17:16], a[17:16], 12'h5C3};
    endfunction

    // memory model: correct word only after every delay has elapsed
    time t_a = 0, t_s = 0, t_r = 0, t_rel = 0;
    always @(mem_addr) t_a = $time;
    always @(negedge mem_sel_n) t_s = $time;
    always @(negedge mem_rden_n) t_r = $time;
    always @(posedge mem_rden_n) t_rel = $time;

    initial begin
        forever begin
            #1;
            if (!mem_sel_n && !mem_rden_n && ($time - t_a >= T_ADDR) &&
                ($time - t_s >= T_SEL) && ($time - t_r >= T_RDEN))
                mem_data_in = rom_word(mem_addr);
            else
                mem_data_in = ~rom_word(mem_addr);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // R7: bus float spacing seen at the memory side
    always @(negedge mem_sel_n) begin
        if (!rst && t_rel != 0)
            chk(($time - t_rel) >= T_FLT, "R7 float gap ns", int'($time - t_rel), T_FLT);
    end

    task automatic check_reset_state(input string tag);
        chk(mem_sel_n == 1'b1, tag, mem_sel_n, 1);
        chk(mem_rden_n == 1'b1, tag, mem_rden_n, 1);
        chk(mem_addr == '0, tag, mem_addr, 0);
        chk(rsp_valid == 1'b0, tag, rsp_valid, 0);
        chk(req_ready == 1'b1, tag, req_ready, 1);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit poke);
        int k;
        int oe_k;
        int n;
        bit addr_bad;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        k = 0;
        addr_bad = 1'b0;
        chk(mem_addr == a, "R2 address driven", mem_addr, a);
        chk(mem_sel_n == 1'b0, "R2 select low", mem_sel_n, 0);
        chk(req_ready == 1'b0, "R2 busy", req_ready, 0);
        oe_k = mem_rden_n ? -1 : 0;
        while (!rsp_valid && k < 100) begin
            if (poke && k == 2) begin
                req_valid = 1'b1;
                req_addr  = a ^ 18'h2AAAA;
            end
            @(negedge clk);
            k++;
            if (oe_k < 0 && !mem_rden_n) oe_k = k;
            if (!rsp_valid && mem_addr != a) addr_bad = 1'b1;
        end
        req_valid = 1'b0;
        chk(oe_k == EXP_LEAD, "R3 read enable lead", oe_k, EXP_LEAD);
        chk(k == EXP_SAMP, "R4 capture cycle", k, EXP_SAMP);
        chk(rsp_data == rom_word(a), "R4 captured word", rsp_data, rom_word(a));
        chk(mem_sel_n && mem_rden_n, "R5 strobes released", {mem_sel_n, mem_rden_n}, 3);
        if (poke)
            chk(!addr_bad, "R8 busy request ignored", addr_bad, 0);
        else
            chk(!addr_bad, "R6 address held", addr_bad, 0);
        n = 0;
        while (!req_ready && n < 100) begin
            @(negedge clk);
            n++;
            if (n == 1) chk(rsp_valid == 1'b0, "R5 single pulse", rsp_valid, 0);
        end
        chk(n == C_FLT, "R7 ready after float", n, C_FLT);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        check_reset_state("R1 reset state");
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem_sel_n == 1'b1, "R9 idle without request", mem_sel_n, 1);
        chk(req_ready == 1'b1, "R9 ready while idle", req_ready, 1);

        do_read(18'h00000, 1'b0);
        do_read(18'h3FFFF, 1'b0);
        do_read(18'h15555, 1'b1);
        for (int i = 0; i < 24; i++) begin
            do_read(AW'($urandom), ($urandom % 3) == 0);
            repeat ($urandom % 3) @(negedge clk);
        end

        // reset in the middle of an access
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 18'h2F0F0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (EXP_LEAD + 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("R1 reset mid-access");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        do_read(18'h0ABCD, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule